// File: doc/BRIEF.md
# Predicated Vector Floating-Point Multiplier

This block multiplies two wide vector registers element by element under a predicate mask. Each element the mask selects is replaced by the product of the first and second operands at that index. Each element the mask does not select keeps the value it had in the first operand. The first operand is therefore also the destination, and the `result` output always shows that register. The vector width `VLEN` is a parameter and must be a multiple of 128 bits. A size input selects 16-bit, 32-bit or 64-bit IEEE elements.

The predicate carries one bit per byte of the vector. An element is selected by the lowest predicate bit of its own byte group. A caller presents both vectors, the predicate and the size, then pulses `start` while the block is idle. The block works through one element per clock. It raises `done` for one cycle once the last element has been written back. Products round to nearest-even and flush subnormals to zero. The block produces no condition flags and no exception flags.

Top module: `vfmul_pred`

## Requirements
- R1: `size` selects the element format: 0 is half precision (16 bit), 1 is single precision (32 bit), and 2 and 3 are both double precision (64 bit). The vector holds VLEN/width elements, and element e occupies bits [e*width +: width].
- R2: An active element whose inputs are both normal becomes the product rounded to nearest, ties to even. If the rounded exponent lies inside the normal range, the result is that normal number.
- R3: An inactive element keeps its first-operand value bit for bit, whatever the second operand holds.
- R4: Element e is active exactly when predicate bit e*(width/8) is 1. The other predicate bits of that element's byte group have no effect.
- R5: With an all-zero predicate the result equals the first operand, even when the second operand is all NaN.
- R6: A subnormal input counts as zero. A product whose rounded exponent falls below the normal range becomes zero. Every zero result carries the XOR of the input signs.
- R7: A NaN input gives the default NaN: sign 0, exponent all ones, and only the top fraction bit set. Infinity times zero gives the same default NaN.
- R8: Infinity times a finite nonzero value, and any finite product that overflows, give infinity signed with the XOR of the input signs.
- R9: A `start` seen while idle begins an operation. `busy` is then high for exactly N cycles, where N is the element count. `done` is high for the single cycle after that, and in that cycle `result` holds the final vector. `result` stays unchanged while the block is idle and no start arrives.
- R10: A `start` that arrives while `busy` is high is ignored. Neither the timing nor the result of the operation in progress changes.
- R11: After reset, `busy` and `done` are low and `result` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation (taken only while idle) |
| size | input | 2 | Element format select |
| pred | input | VLEN/8 | Predicate, one bit per vector byte |
| opa | input | VLEN | First operand (merged into the result) |
| opb | input | VLEN | Second operand |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | VLEN | Destination vector register |

## Verification
The hardest conditions to reach from the ports are a start that collides with a running operation and a predicate whose deciding bits are all clear while the neighbouring bits in each byte group are set. The bench raises start again, with different operands and size, one cycle into a run. It also drives predicates built from per-group patterns such as 1110 next to an all-NaN second operand. The special-value lanes come from a fixed eight-entry pattern rotated across each format: NaN, infinity against zero, subnormal, overflow and underflow. In these lanes flushing, default NaN and sign handling occur at known element positions.

// File: rtl/vfmul_pkg.sv
package vfmul_pkg;

    typedef enum logic [1:0] {
        FMT_HALF   = 2'd0,
        FMT_SINGLE = 2'd1,
        FMT_DOUBLE = 2'd2,
        FMT_WIDE   = 2'd3
    } fmt_e;

    typedef enum logic {S_IDLE, S_RUN} seq_e;

    // Operand unpacked onto a double-width grid (fraction left aligned)
    typedef struct packed {
        logic        sign;
        logic [10:0] exp;
        logic [51:0] frac;
        logic        zero;
        logic        inf;
        logic        nan;
    } fop_t;

    function automatic logic [6:0] man_bits(fmt_e f);
        case (f)
            FMT_HALF:   return 7'd10;
            FMT_SINGLE: return 7'd23;
            default:    return 7'd52;
        endcase
    endfunction

    function automatic logic [3:0] exp_bits(fmt_e f);
        case (f)
            FMT_HALF:   return 4'd5;
            FMT_SINGLE: return 4'd8;
            default:    return 4'd11;
        endcase
    endfunction

    // log2 of the element width in bits
    function automatic logic [2:0] lane_lg2(fmt_e f);
        case (f)
            FMT_HALF:   return 3'd4;
            FMT_SINGLE: return 3'd5;
            default:    return 3'd6;
        endcase
    endfunction

    function automatic logic [10:0] exp_max(fmt_e f);
        return (11'd1 << exp_bits(f)) - 11'd1;
    endfunction

    function automatic logic [10:0] bias_of(fmt_e f);
        return (11'd1 << (exp_bits(f) - 4'd1)) - 11'd1;
    endfunction

    function automatic fop_t unpack_op(fmt_e f, logic [63:0] x);
        fop_t        r;
        logic [6:0]  m;
        logic [63:0] fr;
        m      = man_bits(f);
        fr     = x & ((64'd1 << m) - 64'd1);
        r.sign = x[6'(m + {3'b0, exp_bits(f)})];
        r.exp  = 11'((x >> m) & 64'(exp_max(f)));
        r.frac = 52'(fr << (7'd52 - m));
        r.zero = (r.exp == 11'd0);
        r.inf  = (r.exp == exp_max(f)) && (fr == 64'd0);
        r.nan  = (r.exp == exp_max(f)) && (fr != 64'd0);
        return r;
    endfunction

    function automatic logic [63:0] pack_op(fmt_e f, logic s, logic [10:0] e, logic [51:0] fr);
        logic [6:0] m;
        logic [6:0] top;
        m   = man_bits(f);
        top = m + {3'b0, exp_bits(f)};
        return (64'(s) << top) | (64'(e) << m) | (64'(fr) & ((64'd1 << m) - 64'd1));
    endfunction

endpackage

// File: rtl/vfmul_unit.sv
module vfmul_unit
    import vfmul_pkg::*;
(
    input  fmt_e        fmt,
    input  logic [63:0] a,
    input  logic [63:0] b,
    output logic [63:0] y
);
    fop_t                ua, ub;
    logic [6:0]          m;
    logic [10:0]         emax;
    logic                sgn;
    logic [105:0]        prod, norm;
    logic [52:0]         kept;
    logic [53:0]         rnd;
    logic                grd, stk, carry;
    logic signed [13:0]  exs;
    logic [51:0]         fo;

    always_comb begin
        ua    = unpack_op(fmt, a);
        ub    = unpack_op(fmt, b);
        m     = man_bits(fmt);
        emax  = exp_max(fmt);
        sgn   = ua.sign ^ ub.sign;
        prod  = 106'({1'b1, ua.frac}) * 106'({1'b1, ub.frac});
        norm  = prod[105] ? prod : (prod << 1);
        // keep m+1 significant bits, then guard and sticky below them
        kept  = 53'(norm >> (7'd105 - m));
        grd   = norm[7'd104 - m];
        stk   = |(norm & ((106'd1 << (7'd104 - m)) - 106'd1));
        rnd   = {1'b0, kept} + {53'd0, grd & (stk | kept[0])};
        carry = rnd[6'(m + 7'd1)];
        exs   = $signed({3'b0, ua.exp}) + $signed({3'b0, ub.exp})
              - $signed({3'b0, bias_of(fmt)})
              + $signed({13'd0, prod[105]}) + $signed({13'd0, carry});
        fo    = 52'(carry ? (rnd >> 1) : rnd);

        if (ua.nan || ub.nan || (ua.inf && ub.zero) || (ua.zero && ub.inf))
            y = pack_op(fmt, 1'b0, emax, 52'd1 << (m - 7'd1));
        else if (ua.inf || ub.inf)
            y = pack_op(fmt, sgn, emax, 52'd0);
        else if (ua.zero || ub.zero)
            y = pack_op(fmt, sgn, 11'd0, 52'd0);
        else if (exs >= $signed({3'b0, emax}))
            y = pack_op(fmt, sgn, emax, 52'd0);
        else if (exs <= 14'sd0)
            y = pack_op(fmt, sgn, 11'd0, 52'd0);
        else
            y = pack_op(fmt, sgn, exs[10:0], fo);
    end
endmodule

// File: rtl/vfmul_lane_pick.sv
module vfmul_lane_pick
    import vfmul_pkg::*;
#(
    parameter int VLEN = 256,
    parameter int IDXW = 4
) (
    input  logic [VLEN-1:0]         vec_a,
    input  logic [VLEN-1:0]         vec_b,
    input  logic [VLEN/8-1:0]       pred,
    input  fmt_e                    fmt,
    input  logic [IDXW-1:0]         idx,
    output logic [63:0]             a_el,
    output logic [63:0]             b_el,
    output logic                    active,
    output logic [$clog2(VLEN)-1:0] sh,
    output logic [63:0]             lmask
);
    localparam int SHW = $clog2(VLEN);
    localparam int PIW = $clog2(VLEN / 8);

    logic [PIW-1:0] pbit;

    always_comb begin
        sh    = SHW'(idx) << lane_lg2(fmt);
        pbit  = PIW'(idx) << (lane_lg2(fmt) - 3'd3);
        case (fmt)
            FMT_HALF:   lmask = 64'h0000_0000_0000_FFFF;
            FMT_SINGLE: lmask = 64'h0000_0000_FFFF_FFFF;
            default:    lmask = '1;
        endcase
        a_el   = 64'(vec_a >> sh) & lmask;
        b_el   = 64'(vec_b >> sh) & lmask;
        active = pred[pbit];
    end
endmodule

// File: rtl/vfmul_seq.sv
module vfmul_seq
    import vfmul_pkg::*;
#(
    parameter int IDXW = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    input  logic [IDXW-1:0] last,
    output logic            accept,
    output logic            step,
    output logic [IDXW-1:0] idx,
    output logic            busy,
    output logic            done
);
    seq_e st_q;

    assign accept = (st_q == S_IDLE) && start;
    assign step   = (st_q == S_RUN);
    assign busy   = step;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= S_IDLE;
            idx  <= '0;
            done <= 1'b0;
        end else begin
            done <= 1'b0;
            case (st_q)
                S_IDLE: if (start) begin
                    st_q <= S_RUN;
                    idx  <= '0;
                end
                S_RUN: if (idx == last) begin
                    st_q <= S_IDLE;
                    done <= 1'b1;
                end else begin
                    idx <= idx + 1'b1;
                end
                default: st_q <= S_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/vfmul_pred.sv
module vfmul_pred
    import vfmul_pkg::*;
#(
    parameter int VLEN = 256
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [1:0]        size,
    input  logic [VLEN/8-1:0] pred,
    input  logic [VLEN-1:0]   opa,
    input  logic [VLEN-1:0]   opb,
    output logic              busy,
    output logic              done,
    output logic [VLEN-1:0]   result
);
    localparam int PW   = VLEN / 8;
    localparam int MAXL = VLEN / 16;
    localparam int IDXW = $clog2(MAXL);
    localparam int SHW  = $clog2(VLEN);
    localparam logic [IDXW-1:0] LAST_H = IDXW'(VLEN / 16 - 1);
    localparam logic [IDXW-1:0] LAST_S = IDXW'(VLEN / 32 - 1);
    localparam logic [IDXW-1:0] LAST_D = IDXW'(VLEN / 64 - 1);

    fmt_e            fmt_q;
    logic [VLEN-1:0] acc_q, opb_q;
    logic [PW-1:0]   pred_q;
    logic            accept, step, act;
    logic [IDXW-1:0] idx, last;
    logic [63:0]     a_el, b_el, lmask, prod;
    logic [SHW-1:0]  sh;

    always_comb begin
        case (fmt_q)
            FMT_HALF:   last = LAST_H;
            FMT_SINGLE: last = LAST_S;
            default:    last = LAST_D;
        endcase
    end

    vfmul_seq #(.IDXW(IDXW)) seq_i (
        .clk(clk), .rst(rst), .start(start), .last(last),
        .accept(accept), .step(step), .idx(idx), .busy(busy), .done(done)
    );

    vfmul_lane_pick #(.VLEN(VLEN), .IDXW(IDXW)) pick_i (
        .vec_a(acc_q), .vec_b(opb_q), .pred(pred_q), .fmt(fmt_q), .idx(idx),
        .a_el(a_el), .b_el(b_el), .active(act), .sh(sh), .lmask(lmask)
    );

    vfmul_unit mul_i (.fmt(fmt_q), .a(a_el), .b(b_el), .y(prod));

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q  <= '0;
            opb_q  <= '0;
            pred_q <= '0;
            fmt_q  <= FMT_HALF;
        end else if (accept) begin
            acc_q  <= opa;
            opb_q  <= opb;
            pred_q <= pred;
            fmt_q  <= fmt_e'(size);
        end else if (step && act) begin
            acc_q <= (acc_q & ~(VLEN'(lmask) << sh)) | (VLEN'(prod & lmask) << sh);
        end
    end

    assign result = acc_q;
endmodule

// File: rtl/vfmul_chk.sv
module vfmul_chk #(
    parameter int VLEN = 256
) (
    input logic            clk,
    input logic            rst,
    input logic            start,
    input logic            busy,
    input logic            done,
    input logic [VLEN-1:0] result
);
    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst) done |=> !done);
    // R9
    done_idle_chk: assert property (@(posedge clk) disable iff (rst) done |-> !busy);
    // R9
    done_after_run_chk: assert property (@(posedge clk) disable iff (rst) done |-> $past(busy));
    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst) (!busy && !start) |=> $stable(result));
    // R10
    busy_start_chk: assert property (@(posedge clk) disable iff (rst) (busy && start) |=> (busy || done));
endmodule

bind vfmul_pred vfmul_chk #(.VLEN(VLEN)) chk_i (
    .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done), .result(result)
);

// File: tb/vfmul_pred_tb.sv
module vfmul_pred_tb_top;
    localparam int VLEN = 256;
    localparam int PW   = VLEN / 8;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            start = 1'b0;
    logic [1:0]      size = 2'd0;
    logic [PW-1:0]   pred = '0;
    logic [VLEN-1:0] opa = '0, opb = '0;
    logic            busy, done;
    logic [VLEN-1:0] result;

    vfmul_pred #(.VLEN(VLEN)) dut_i (
        .clk(clk), .rst(rst), .start(start), .size(size), .pred(pred),
        .opa(opa), .opb(opb), .busy(busy), .done(done), .result(result)
    );

    always #4 clk = ~clk;

    int n_chk = 0, n_err = 0;
    bit finished = 0;

    task automatic chk(bit ok, string req, string what, logic [63:0] got, logic [63:0] expv);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, got, expv);
        end
    endtask

    function automatic int tb_m(logic [1:0] sz);
        return sz == 2'd0 ? 10 : (sz == 2'd1 ? 23 : 52);
    endfunction
    function automatic int tb_e(logic [1:0] sz);
        return sz == 2'd0 ? 5 : (sz == 2'd1 ? 8 : 11);
    endfunction
    function automatic int tb_w(logic [1:0] sz);
        return sz == 2'd0 ? 16 : (sz == 2'd1 ? 32 : 64);
    endfunction

    // cycle model of the handshake
    bit exp_busy = 0, exp_done = 0;
    int rem = 0;
    always @(posedge clk) begin
        if (rst) begin
            exp_busy = 0; exp_done = 0; rem = 0;
        end else begin
            exp_done = 0;
            if (exp_busy) begin
                rem--;
                if (rem == 0) begin exp_busy = 0; exp_done = 1; end
            end else if (start) begin
                exp_busy = 1;
                rem = VLEN / tb_w(size);
            end
        end
    end

    always @(negedge clk) begin
        if (!rst && !finished)
            chk(busy === exp_busy && done === exp_done, "R9", "busy/done timing",
                {62'd0, busy, done}, {62'd0, exp_busy, exp_done});
    end

    function automatic logic [63:0] mk(logic [1:0] sz, bit s, longint e, longint f);
        int m = tb_m(sz), eb = tb_e(sz);
        return (64'(s) << (m + eb)) | (64'(e) << m) | (64'(f) & ((64'd1 << m) - 64'd1));
    endfunction

    function automatic logic [63:0] rnd_lane(logic [1:0] sz);
        int eb = tb_e(sz);
        int bias = (1 << (eb - 1)) - 1;
        int q = bias / 2;
        longint e = longint'(bias - q + int'($urandom_range(2 * q, 0)));
        return mk(sz, bit'($urandom & 1), e, {$urandom, $urandom});
    endfunction

    function automatic logic [63:0] ref_mul(logic [1:0] sz, logic [63:0] a, logic [63:0] b, output string tag);
        int m = tb_m(sz), eb = tb_e(sz);
        int bias = (1 << (eb - 1)) - 1, emax = (1 << eb) - 1;
        int xa = int'((a >> m) & 64'(emax)), xb = int'((b >> m) & 64'(emax));
        logic [63:0] fa = a & ((64'd1 << m) - 1), fb = b & ((64'd1 << m) - 1);
        bit s = a[m + eb] ^ b[m + eb];
        logic [63:0] qnan = mk(sz, 0, emax, 64'd1 << (m - 1));
        logic [63:0] infv = mk(sz, s, emax, 0);
        logic [63:0] zv = mk(sz, s, 0, 0);
        bit na = xa == emax && fa != 0, nb = xb == emax && fb != 0;
        bit ia = xa == emax && fa == 0, ib = xb == emax && fb == 0;
        bit za = xa == 0, zb = xb == 0;
        if (na || nb || (ia && zb) || (za && ib)) begin tag = "R7"; return qnan; end
        if (ia || ib) begin tag = "R8"; return infv; end
        if (za || zb) begin tag = "R6"; return zv; end
        if (m == 52) begin
            real p;
            logic [63:0] r;
            p = $bitstoreal({1'b0, a[62:0]}) * $bitstoreal({1'b0, b[62:0]});
            r = $realtobits(p);
            if (r[62:52] == 11'd0) begin tag = "R6"; return zv; end
            if (r[62:52] == 11'h7FF) begin tag = "R8"; return infv; end
            tag = "R2";
            return {s, r[62:0]};
        end else begin
            real mm, lo, hi, fl, fr;
            int k, be;
            lo = real'(64'd1 << m);
            hi = 2.0 * lo;
            mm = real'((64'd1 << m) + fa) * real'((64'd1 << m) + fb);
            k = xa + xb - 2 * bias - 2 * m;
            while (mm >= hi) begin mm = mm / 2.0; k++; end
            fl = $floor(mm);
            fr = mm - fl;
            if (fr > 0.5 || (fr == 0.5 && (longint'(fl) % 2) == 1)) fl = fl + 1.0;
            if (fl >= hi) begin fl = fl / 2.0; k++; end
            be = k + m + bias;
            if (be >= emax) begin tag = "R8"; return infv; end
            if (be <= 0) begin tag = "R6"; return zv; end
            tag = "R2";
            return mk(sz, s, be, longint'(fl) - (longint'(1) << m));
        end
    endfunction

    function automatic logic [63:0] get_lane(logic [VLEN-1:0] v, logic [1:0] sz, int e);
        int w = tb_w(sz);
        return 64'(v >> (e * w)) & (w == 64 ? '1 : ((64'd1 << w) - 1));
    endfunction

    task automatic run_op(string rtag, logic [1:0] sz, logic [VLEN-1:0] a, logic [VLEN-1:0] b,
                          logic [PW-1:0] p, bit poke);
        int w = tb_w(sz), n = VLEN / tb_w(sz), bytes = tb_w(sz) / 8;
        logic [63:0] ev[16];
        string tg[16];
        int guard = 0;
        for (int e = 0; e < n; e++) begin
            logic [63:0] al = get_lane(a, sz, e);
            bit act = p[e * bytes];
            if (act) ev[e] = ref_mul(sz, al, get_lane(b, sz, e), tg[e]);
            else begin
                ev[e] = al;
                if (p == '0) tg[e] = "R5";
                else if (((p >> (e * bytes)) & ((1 << bytes) - 1)) != 0) tg[e] = "R4";
                else tg[e] = "R3";
            end
        end
        @(negedge clk);
        size = sz; opa = a; opb = b; pred = p; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (poke) begin
            // R10: second start during the run, different operands
            opa = ~a; opb = ~b; pred = '1; size = 2'd0; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        while (done !== 1'b1 && guard < 200) begin @(negedge clk); guard++; end
        for (int e = 0; e < n; e++) begin
            logic [63:0] g = get_lane(result, sz, e);
            chk(g === ev[e], tg[e], $sformatf("%s lane %0d", rtag, e), g, ev[e]);
        end
        @(negedge clk);
        @(negedge clk);
        for (int e = 0; e < n; e++) begin
            logic [63:0] g = get_lane(result, sz, e);
            chk(g === ev[e], "R9", $sformatf("%s idle hold lane %0d", rtag, e), g, ev[e]);
        end
    endtask

    function automatic logic [VLEN-1:0] rnd_vec(logic [1:0] sz);
        logic [VLEN-1:0] v = '0;
        for (int e = 0; e < VLEN / tb_w(sz); e++) v |= VLEN'(rnd_lane(sz)) << (e * tb_w(sz));
        return v;
    endfunction

    function automatic logic [63:0] spec_lane(logic [1:0] sz, int i, bit second);
        int eb = tb_e(sz), m = tb_m(sz);
        int bias = (1 << (eb - 1)) - 1, emax = (1 << eb) - 1;
        case (i % 8)
            0: return second ? mk(sz, 0, bias, 0) : mk(sz, 0, emax, 1);
            1: return second ? mk(sz, 1, bias, 64'd1 << (m - 1)) : mk(sz, 0, emax, 0);
            2: return second ? mk(sz, 0, 0, 0) : mk(sz, 1, emax, 0);
            3: return second ? mk(sz, 0, bias + 1, 7) : mk(sz, 1, 0, 0);
            4: return second ? mk(sz, 1, bias, 0) : mk(sz, 0, 0, 5);
            5: return second ? mk(sz, 0, emax - 1, 3) : mk(sz, 1, emax - 1, '1);
            6: return second ? mk(sz, 0, 1, 3) : mk(sz, 0, 1, 0);
            default: return second ? mk(sz, 1, emax, 3) : mk(sz, 1, bias, 0);
        endcase
    endfunction

    task automatic spec_run(string rtag, logic [1:0] sz, int off);
        logic [VLEN-1:0] a = '0, b = '0;
        for (int e = 0; e < VLEN / tb_w(sz); e++) begin
            a |= VLEN'(spec_lane(sz, e + off, 0)) << (e * tb_w(sz));
            b |= VLEN'(spec_lane(sz, e + off, 1)) << (e * tb_w(sz));
        end
        run_op(rtag, sz, a, b, '1, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11
        chk(busy === 1'b0 && done === 1'b0, "R11", "reset flags", {62'd0, busy, done}, 64'd0);
        chk(result === '0, "R11", "reset result", result[63:0], 64'd0);

        run_op("R2 single", 2'd1, rnd_vec(2'd1), rnd_vec(2'd1), '1, 0);
        run_op("R2 single b", 2'd1, rnd_vec(2'd1), rnd_vec(2'd1), '1, 0);
        run_op("R2 half", 2'd0, rnd_vec(2'd0), rnd_vec(2'd0), '1, 0);
        run_op("R2 double", 2'd2, rnd_vec(2'd2), rnd_vec(2'd2), '1, 0);
        run_op("R1 code3", 2'd3, rnd_vec(2'd2), rnd_vec(2'd2), '1, 0);
        run_op("R3 half mixed", 2'd0, rnd_vec(2'd0), rnd_vec(2'd0), PW'({$urandom, $urandom}), 0);
        run_op("R3 double mixed", 2'd2, rnd_vec(2'd2), rnd_vec(2'd2), {PW/8{8'h0F, 8'hF1}}, 0);
        run_op("R4 single upper bits", 2'd1, rnd_vec(2'd1), '1, {PW/4{4'b1110}}, 0);
        run_op("R4 single alternate", 2'd1, rnd_vec(2'd1), rnd_vec(2'd1), {PW/8{4'b1110, 4'b0001}}, 0);
        run_op("R5 no active", 2'd2, rnd_vec(2'd2), '1, '0, 0);
        spec_run("R7 half specials", 2'd0, 0);
        spec_run("R8 single specials", 2'd1, 0);
        spec_run("R6 double specials a", 2'd2, 0);
        spec_run("R6 double specials b", 2'd2, 4);
        run_op("R10 start while busy", 2'd1, rnd_vec(2'd1), rnd_vec(2'd1), {PW/4{4'b0001}}, 1);
        run_op("R10 half poke", 2'd0, rnd_vec(2'd0), rnd_vec(2'd0), '1, 1);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule